// File: doc/BRIEF.md
# Indexed Interrupt Redirection Router

This block routes a set of external interrupt lines to processors. Each input pin owns a 64-bit routing entry that says whether the pin is blocked and which vector it carries. The entry also holds the delivery mode, the destination addressing mode, the active polarity, the trigger type and a 4-bit destination. When a pin that is not blocked becomes active, the block emits a one-cycle delivery message built from that pin's entry.

Software reaches all state through two 32-bit locations. The first is a select register, which holds an 8-bit register index. The second is a data window, which reads or writes whichever register that index names. Index 0 is an identification register with a writable 4-bit unit number. Each pin N has two words: its low word sits at index 16 + 2N and its high word at index 17 + 2N. Blocking or releasing a pin is a read-modify-write of the low word.

Edge-type pins raise one message for each transition into the active level. Level-type pins raise one message and then hold off until an end-of-interrupt naming the pin arrives.

Top module: `irq_route_ctrl`

## Requirements
- R1: A write with `bus_win`=0 stores `bus_wdata[7:0]` as the index. A read with `bus_win`=0 returns the index in bits 7:0 and zero in bits 31:8.
- R2: The window at index 16+2N reads and writes pin N's low word. Its fields are: bits 7:0 vector, bits 10:8 delivery mode (0 fixed, 1 lowest priority), bit 11 logical destination, bit 13 active-low, bit 15 level trigger and bit 16 mask. Index 17+2N holds the destination in bits 27:24. All other bits read zero, except bit 14 of the low word, which shows whether the pin is in service.
- R3: After reset, every low word reads 0x0001_0000, every high word and the identification register read zero, and no message is emitted.
- R4: A pin whose mask bit is set emits no message, whatever its input does.
- R5: An unmasked edge pin emits exactly one message, in the cycle after its input is first sampled active. It emits nothing more while the input stays active, and a later fresh activation emits again.
- R6: An unmasked level pin emits one message when its input is sampled active, then sets low-word bit 14 and emits nothing further. An end-of-interrupt for that pin clears bit 14; if the input is still active, a new message follows one cycle later.
- R7: Low-word bit 13 set makes a low input the active level.
- R8: A message presents the pin number, vector, delivery mode, destination mode, destination and a flag that is 1 for a level pin.
- R9: Index 0 keeps a 4-bit identifier in bits 27:24 that is writable; all its other bits read zero.
- R10: Indices outside 0 and 16..16+2*NPINS-1 read zero, and writes to them change nothing.
- R11: At most one message is emitted per cycle. Among pins requesting at once, the lowest number goes first, and the others stay pending and follow in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_win | input | 1 | 0 selects the index register, 1 the data window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the location chosen by `bus_win` |
| irq_in | input | NPINS | Interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_pin | input | PIN_W | Pin that the end-of-interrupt releases |
| msg_valid | output | 1 | Delivery message present this cycle |
| msg_pin | output | PIN_W | Source pin of the message |
| msg_vector | output | 8 | Vector |
| msg_dlv | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_dest | output | 4 | Destination |
| msg_level | output | 1 | 1 when the source pin is level-triggered |

## Verification
Some properties are checked on every cycle: the upper bits of an index read stay zero, and no message is emitted during reset. Each message must come from a pin that was unmasked in the cycle before. The message's level flag must match that pin's trigger setting, no two grants occur at once, and a level message is never repeated in the next cycle. Other behaviour needs the bench's directed sequences: the exact field layout through the window, and the silence of unimplemented indices. The same holds for one message per edge, re-delivery after an end-of-interrupt, inverted polarity, and the order in which simultaneous pins drain.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // One routing entry as held in the table
  typedef struct packed {
    logic       mask;
    logic       level;
    logic       act_low;
    logic       logical;
    logic [2:0] dlv;
    logic [7:0] vec;
    logic [3:0] dest;
  } route_ent_t;

  localparam int LO_VEC_LSB     = 0;
  localparam int LO_DLV_LSB     = 8;
  localparam int LO_LOGICAL_BIT = 11;
  localparam int LO_ACTLOW_BIT  = 13;
  localparam int LO_INSVC_BIT   = 14;
  localparam int LO_LEVEL_BIT   = 15;
  localparam int LO_MASK_BIT    = 16;
  localparam int HI_DEST_LSB    = 24;
  localparam int ID_LSB         = 24;

  localparam route_ent_t ENT_RESET = route_ent_t'({1'b1, 18'd0});

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NPINS    = 16,
  parameter int IDX_W    = 8,
  parameter int TBL_BASE = 16,
  parameter int ID_IDX   = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_win,
  input  logic                    bus_we,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NPINS-1:0]        insvc,
  output route_ent_t [NPINS-1:0]  tbl
);

  logic [IDX_W-1:0]       sel_q, sel_d;
  logic                   sel_en;
  logic [3:0]             id_q, id_d;
  logic                   id_en;
  route_ent_t [NPINS-1:0] tbl_q, tbl_d;
  logic                   tbl_en;
  logic                   win_wr;
  logic [IDX_W-1:0]       off;
  logic                   in_tbl;
  logic                   hi_half;
  logic [IDX_W-2:0]       ent_idx;
  logic [31:0]            win_rd;
  logic                   unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

  assign win_wr  = bus_win & bus_we;
  assign off     = sel_q - IDX_W'(TBL_BASE);
  assign in_tbl  = (sel_q >= IDX_W'(TBL_BASE)) && (off < IDX_W'(2 * NPINS));
  assign hi_half = off[0];
  assign ent_idx = off[IDX_W-1:1];

  // next state
  assign sel_en = bus_we & ~bus_win;
  assign sel_d  = bus_wdata[IDX_W-1:0];
  assign id_en  = win_wr && (sel_q == IDX_W'(ID_IDX));
  assign id_d   = bus_wdata[ID_LSB +: 4];
  assign tbl_en = win_wr & in_tbl;

  always_comb begin
    tbl_d = tbl_q;
    for (int p = 0; p < NPINS; p++) begin
      if (in_tbl && ent_idx == (IDX_W-1)'(p)) begin
        if (hi_half) begin
          tbl_d[p].dest = bus_wdata[HI_DEST_LSB +: 4];
        end else begin
          tbl_d[p].vec     = bus_wdata[LO_VEC_LSB +: 8];
          tbl_d[p].dlv     = bus_wdata[LO_DLV_LSB +: 3];
          tbl_d[p].logical = bus_wdata[LO_LOGICAL_BIT];
          tbl_d[p].act_low = bus_wdata[LO_ACTLOW_BIT];
          tbl_d[p].level   = bus_wdata[LO_LEVEL_BIT];
          tbl_d[p].mask    = bus_wdata[LO_MASK_BIT];
        end
      end
    end
  end

  // read path
  always_comb begin
    win_rd = '0;
    if (sel_q == IDX_W'(ID_IDX)) win_rd[ID_LSB +: 4] = id_q;
    for (int p = 0; p < NPINS; p++) begin
      if (in_tbl && ent_idx == (IDX_W-1)'(p)) begin
        if (hi_half) begin
          win_rd[HI_DEST_LSB +: 4] = tbl_q[p].dest;
        end else begin
          win_rd[LO_VEC_LSB +: 8]  = tbl_q[p].vec;
          win_rd[LO_DLV_LSB +: 3]  = tbl_q[p].dlv;
          win_rd[LO_LOGICAL_BIT]   = tbl_q[p].logical;
          win_rd[LO_ACTLOW_BIT]    = tbl_q[p].act_low;
          win_rd[LO_INSVC_BIT]     = insvc[p];
          win_rd[LO_LEVEL_BIT]     = tbl_q[p].level;
          win_rd[LO_MASK_BIT]      = tbl_q[p].mask;
        end
      end
    end
  end

  assign bus_rdata = bus_win ? win_rd : {{(32-IDX_W){1'b0}}, sel_q};
  assign tbl       = tbl_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
      for (int p = 0; p < NPINS; p++) tbl_q[p] <= ENT_RESET;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (id_en)  id_q  <= id_d;
      if (tbl_en) tbl_q <= tbl_d;
    end
  end

endmodule

// File: rtl/irq_route_pin.sv
module irq_route_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic mask,
  input  logic level,
  input  logic act_low,
  input  logic grant,
  input  logic eoi_hit,
  output logic req,
  output logic insvc
);

  logic prev_q, pend_q, insvc_q;
  logic pend_d, insvc_d;
  logic active, rise;

  assign active = irq ^ act_low;
  assign rise   = active & ~prev_q;

  always_comb begin
    if (mask)       req = 1'b0;
    else if (level) req = active & ~insvc_q;
    else            req = pend_q | rise;
  end

  assign pend_d  = level ? 1'b0 : ((pend_q | (rise & ~mask)) & ~grant);
  assign insvc_d = level ? ((insvc_q | grant) & ~eoi_hit) : 1'b0;
  assign insvc   = insvc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      prev_q  <= active;
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
  parameter int NPINS = 16,
  parameter int PIN_W = 4
) (
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] grant,
  output logic             any,
  output logic [PIN_W-1:0] pin
);

  assign grant = req & (~req + NPINS'(1));
  assign any   = |req;

  always_comb begin
    pin = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (grant[p]) pin = PIN_W'(p);
    end
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NPINS    = 16,
  parameter int IDX_W    = 8,
  parameter int TBL_BASE = 16,
  parameter int ID_IDX   = 0,
  localparam int PIN_W   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_win,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] irq_in,
  input  logic             eoi_valid,
  input  logic [PIN_W-1:0] eoi_pin,
  output logic             msg_valid,
  output logic [PIN_W-1:0] msg_pin,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_dlv,
  output logic             msg_logical,
  output logic [3:0]       msg_dest,
  output logic             msg_level
);

  logic [1:0]             rst_sync_q;
  logic                   rst_i_n;
  route_ent_t [NPINS-1:0] tbl;
  logic [NPINS-1:0]       req, grant, insvc, eoi_hit;
  logic                   gnt_any;
  logic [PIN_W-1:0]       gnt_pin;
  route_ent_t             gnt_ent;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  irq_route_regs #(
    .NPINS(NPINS), .IDX_W(IDX_W), .TBL_BASE(TBL_BASE), .ID_IDX(ID_IDX)
  ) regs_i (
    .clk(clk), .rst_n(rst_i_n), .bus_win(bus_win), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .insvc(insvc), .tbl(tbl)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign eoi_hit[p] = eoi_valid && (eoi_pin == PIN_W'(p));
    irq_route_pin pin_i (
      .clk(clk), .rst_n(rst_i_n), .irq(irq_in[p]),
      .mask(tbl[p].mask), .level(tbl[p].level), .act_low(tbl[p].act_low),
      .grant(grant[p]), .eoi_hit(eoi_hit[p]), .req(req[p]), .insvc(insvc[p])
    );
  end

  irq_route_arb #(.NPINS(NPINS), .PIN_W(PIN_W)) arb_i (
    .req(req), .grant(grant), .any(gnt_any), .pin(gnt_pin)
  );

  assign gnt_ent = tbl[gnt_pin];

  // message register
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      msg_valid   <= 1'b0;
      msg_pin     <= '0;
      msg_vector  <= '0;
      msg_dlv     <= '0;
      msg_logical <= 1'b0;
      msg_dest    <= '0;
      msg_level   <= 1'b0;
    end else begin
      msg_valid <= gnt_any;
      if (gnt_any) begin
        msg_pin     <= gnt_pin;
        msg_vector  <= gnt_ent.vec;
        msg_dlv     <= gnt_ent.dlv;
        msg_logical <= gnt_ent.logical;
        msg_dest    <= gnt_ent.dest;
        msg_level   <= gnt_ent.level;
      end
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int PIN_W = 4,
  parameter int IDX_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_win,
  input logic [31:0]            bus_rdata,
  input logic                   msg_valid,
  input logic [PIN_W-1:0]       msg_pin,
  input logic                   msg_level,
  input route_ent_t [NPINS-1:0] tbl,
  input logic [NPINS-1:0]       grant
);

  logic [NPINS-1:0] mask_vec, level_vec, pin_bit;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      mask_vec[p]  = tbl[p].mask;
      level_vec[p] = tbl[p].level;
    end
  end
  assign pin_bit = NPINS'(1) << msg_pin;

  assert_sel_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_win |-> bus_rdata[31:IDX_W] == '0);

  assert_reset_quiet_R3: assert property (@(posedge clk)
    !rst_n |=> !msg_valid);

  assert_masked_no_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ($past(mask_vec) & pin_bit) == '0);

  assert_level_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_level == (($past(level_vec) & pin_bit) != '0));

  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_level_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_level) |=> !(msg_valid && msg_level && msg_pin == $past(msg_pin)));

endmodule

bind irq_route_ctrl irq_route_chk #(.NPINS(NPINS), .PIN_W(PIN_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_rdata(bus_rdata),
  .msg_valid(msg_valid), .msg_pin(msg_pin), .msg_level(msg_level),
  .tbl(tbl), .grant(grant)
);

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb_top;

  localparam int NPINS = 16;
  localparam int PIN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_win, bus_we;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NPINS-1:0] irq_in;
  logic             eoi_valid;
  logic [PIN_W-1:0] eoi_pin;
  logic             msg_valid, msg_logical, msg_level;
  logic [PIN_W-1:0] msg_pin;
  logic [7:0]       msg_vector;
  logic [2:0]       msg_dlv;
  logic [3:0]       msg_dest;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_pin(eoi_pin), .msg_valid(msg_valid),
    .msg_pin(msg_pin), .msg_vector(msg_vector), .msg_dlv(msg_dlv),
    .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_level(msg_level)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // expected entry contents, computed per pin
  function automatic logic [7:0] f_vec(int p);  return 8'(p * 7 + 32); endfunction
  function automatic logic [2:0] f_dlv(int p);  return 3'(p % 2); endfunction
  function automatic logic       f_dm(int p);   return 1'((p >> 1) & 1); endfunction
  function automatic logic [3:0] f_dest(int p); return 4'((p * 5 + 3) % 16); endfunction
  function automatic logic [31:0] f_lo(int p, logic m, logic lv, logic pol);
    return (32'(m) << 16) | (32'(lv) << 15) | (32'(pol) << 13) |
           (32'(f_dm(p)) << 11) | (32'(f_dlv(p)) << 8) | 32'(f_vec(p));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] d);
    @(negedge clk); bus_win = 1'b0; bus_we = 1'b1; bus_wdata = 32'(idx);
    @(negedge clk); bus_win = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_win = 1'b0;
  endtask

  task automatic reg_rd(input int idx, output logic [31:0] d);
    @(negedge clk); bus_win = 1'b0; bus_we = 1'b1; bus_wdata = 32'(idx);
    @(negedge clk); bus_we = 1'b0; bus_win = 1'b1;
    #1 d = bus_rdata;
    bus_win = 1'b0;
  endtask

  task automatic expect_msg(input string req, input int p, input logic lv);
    chk(req, 32'(msg_valid), 32'd1);
    chk(req, 32'(msg_pin), 32'(p));
    chk(req, 32'(msg_vector), 32'(f_vec(p)));
    chk(req, 32'(msg_dlv), 32'(f_dlv(p)));
    chk(req, 32'(msg_logical), 32'(f_dm(p)));
    chk(req, 32'(msg_dest), 32'(f_dest(p)));
    chk(req, 32'(msg_level), 32'(lv));
  endtask

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_win = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    irq_in = '0; eoi_valid = 1'b0; eoi_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: reset contents
    chk("R3 no msg", 32'(msg_valid), 32'd0);
    for (int p = 0; p < NPINS; p++) begin
      reg_rd(16 + 2 * p, rd); chk("R3 low word", rd, 32'h0001_0000);
      reg_rd(17 + 2 * p, rd); chk("R3 high word", rd, 32'h0);
    end
    reg_rd(0, rd); chk("R3 id", rd, 32'h0);

    // R1: index register readback
    @(negedge clk); bus_win = 1'b0; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFA5;
    @(negedge clk); bus_we = 1'b0;
    #1 chk("R1 index read", bus_rdata, 32'h0000_00A5);

    // R9: identification register
    reg_wr(0, 32'hFFFF_FFFF); reg_rd(0, rd); chk("R9 id all ones", rd, 32'h0F00_0000);
    reg_wr(0, 32'h0500_0000); reg_rd(0, rd); chk("R9 id value", rd, 32'h0500_0000);

    // R10: unimplemented indices
    for (int i = 1; i < 256; i++) begin
      if (i < 16 || i >= 16 + 2 * NPINS) begin
        reg_wr(i, 32'hFFFF_FFFF);
        reg_rd(i, rd); chk("R10 unimplemented read", rd, 32'h0);
      end
    end
    reg_rd(0, rd);  chk("R10 id untouched", rd, 32'h0500_0000);
    reg_rd(16, rd); chk("R10 table untouched", rd, 32'h0001_0000);

    // R2: field layout sweep, junk in reserved bits
    for (int p = 0; p < NPINS; p++) begin
      reg_wr(16 + 2 * p, f_lo(p, 1'b1, 1'b0, 1'b0) | 32'hFE00_5000);
      reg_wr(17 + 2 * p, (32'(f_dest(p)) << 24) | 32'hF0FF_FFFF);
      reg_rd(16 + 2 * p, rd); chk("R2 low word", rd, f_lo(p, 1'b1, 1'b0, 1'b0));
      reg_rd(17 + 2 * p, rd); chk("R2 high word", rd, 32'(f_dest(p)) << 24);
    end

    // R4: masked pin stays silent
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (4) begin @(negedge clk); chk("R4 masked", 32'(msg_valid), 32'd0); end
    irq_in[3] = 1'b0;
    @(negedge clk);

    // R5, R8: edge sweep over every pin
    for (int p = 0; p < NPINS; p++) begin
      reg_wr(16 + 2 * p, f_lo(p, 1'b0, 1'b0, 1'b0));
      @(negedge clk); irq_in[p] = 1'b1;
      @(negedge clk); expect_msg("R5 R8 edge msg", p, 1'b0);
      @(negedge clk); chk("R5 single msg", 32'(msg_valid), 32'd0);
      @(negedge clk); chk("R5 held high", 32'(msg_valid), 32'd0);
      irq_in[p] = 1'b0;
      @(negedge clk); chk("R5 falling", 32'(msg_valid), 32'd0);
    end
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); expect_msg("R5 second edge", 5, 1'b0);
    irq_in[5] = 1'b0;
    @(negedge clk);

    // R11: two pins, then all pins at once
    irq_in[9] = 1'b1; irq_in[2] = 1'b1;
    @(negedge clk); expect_msg("R11 first", 2, 1'b0);
    @(negedge clk); expect_msg("R11 second", 9, 1'b0);
    @(negedge clk); chk("R11 drained", 32'(msg_valid), 32'd0);
    irq_in = '0;
    @(negedge clk);
    irq_in = '1;
    for (int p = 0; p < NPINS; p++) begin
      @(negedge clk); expect_msg("R11 order", p, 1'b0);
    end
    @(negedge clk); chk("R11 all drained", 32'(msg_valid), 32'd0);
    irq_in = '0;
    @(negedge clk);

    // R7: active-low pin
    reg_wr(16 + 12, f_lo(6, 1'b1, 1'b0, 1'b0));
    @(negedge clk); irq_in[6] = 1'b1;
    reg_wr(16 + 12, f_lo(6, 1'b0, 1'b0, 1'b1));
    @(negedge clk); chk("R7 high inactive", 32'(msg_valid), 32'd0);
    irq_in[6] = 1'b0;
    @(negedge clk); expect_msg("R7 low active", 6, 1'b0);
    irq_in[6] = 1'b1;
    @(negedge clk); chk("R7 release", 32'(msg_valid), 32'd0);

    // R6: level pin with end-of-interrupt
    reg_wr(16 + 8, f_lo(4, 1'b0, 1'b1, 1'b0));
    @(negedge clk); irq_in[4] = 1'b1;
    @(negedge clk); expect_msg("R6 level msg", 4, 1'b1);
    repeat (3) begin @(negedge clk); chk("R6 held off", 32'(msg_valid), 32'd0); end
    reg_rd(16 + 8, rd); chk("R6 in service", rd, f_lo(4, 1'b0, 1'b1, 1'b0) | 32'h0000_4000);
    @(negedge clk); eoi_valid = 1'b1; eoi_pin = 4'd4;
    @(negedge clk); eoi_valid = 1'b0;
    @(negedge clk); expect_msg("R6 redeliver", 4, 1'b1);
    @(negedge clk); irq_in[4] = 1'b0;
    @(negedge clk); eoi_valid = 1'b1; eoi_pin = 4'd4;
    @(negedge clk); eoi_valid = 1'b0;
    repeat (3) begin @(negedge clk); chk("R6 inactive after eoi", 32'(msg_valid), 32'd0); end
    reg_rd(16 + 8, rd); chk("R6 service cleared", rd, f_lo(4, 1'b0, 1'b1, 1'b0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule